// File: doc/BRIEF.md
# Transmit Cell Buffer with Whole-Cell Commit

This block sits between the receiving side of a cell-based transmit bus and the cell processor that follows it. The source pushes a cell one word at a time. The words land in shared storage under a tentative write position. Only when the final word of the cell is accepted does the cell count as stored, and only then can the reader see it. If the input side decides that the cell is damaged (a parity fault or a short cell), it raises a discard strobe. The tentative words are then thrown away and the write position falls back to the last cell boundary, so the bad cell never reaches the reader.

The physical store holds sixteen cells. A two-bit setting limits the working capacity to four, eight, twelve or sixteen cells. The block reports empty and full. It also drives a cell-available flag that tells the source whether one more complete cell fits. The reader pulls words from the oldest stored cell and sees a start-of-cell mark on the first word of each cell. Everything runs on one clock.

Top module: `txcell_fifo`

## Requirements
- R1: After reset, fifo_empty=1, fifo_full=0, cell_avail=1 and rd_valid=0.
- R2: A cell becomes readable (rd_valid=1) in the cycle after its last word (word CELL_WORDS-1) is accepted. It is not readable before that.
- R3: Cells are read in the order they were committed. Each word appears on rd_data exactly as it was written.
- R4: rd_soc is 1 on the first word of each cell and 0 on every other word. rd_soc is never 1 while rd_valid is 0.
- R5: wr_drop discards every word of the cell in progress and restarts the cell at word 0. A word offered in the same cycle as wr_drop is discarded too. wr_drop has no effect on committed cells.
- R6: The depth code cfg_depth selects a capacity of (code+1)*4 cells: 0 gives 4, 1 gives 8, 2 gives 12 and 3 gives 16. fifo_full is 1 exactly when the committed cell count equals that capacity. fifo_empty is 1 exactly when the count is zero.
- R7: cell_avail is 1 only when the committed cells plus any cell in progress leave at least one whole cell slot free.
- R8: A cell whose first word arrives while cell_avail=0 is ignored in full. The next cell after it is handled normally.
- R9: A new cfg_depth value takes effect only while the buffer is empty and no cell is in progress. Until then the previous capacity stays in force.
- R10: While rd_en=0, rd_data, rd_soc and rd_valid hold their values. rd_en has no effect while rd_valid=0.
- R11: Committing one cell and releasing another in the same cycle leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Capacity code: (code+1)*4 cells |
| wr_en | input | 1 | Word offered on wr_data |
| wr_data | input | WORD_W | Cell word from the source |
| wr_drop | input | 1 | Discard the cell in progress |
| cell_avail | output | 1 | Room for one more whole cell |
| fifo_empty | output | 1 | No committed cell present |
| fifo_full | output | 1 | Committed cells equal capacity |
| rd_en | input | 1 | Reader consumes the current word |
| rd_data | output | WORD_W | Current word of the oldest cell |
| rd_valid | output | 1 | A committed cell is available |
| rd_soc | output | 1 | Current word is the first of its cell |

## Verification
The bench looks at rd_valid one word before a cell completes. A design that exposes tentative words would show a partial cell there. The discard is tested in the middle of a cell and in the same cycle as a word. A write position that failed to rewind would shift every later cell, and the bench would see the wrong word indices. The bench fills the smallest capacity to its limit, then offers one more cell and checks that it vanishes and that the next cell is clean. It also changes the depth code while cells are stored, so a design that applied the new value at once would report full at the wrong count. A concurrent write and read checks that a commit and a release in the same cycle do not skew the count.

// File: rtl/txcf_pkg.sv
package txcf_pkg;
  // number of depth codes: the physical store is split into this many quarters
  localparam int unsigned DEPTH_STEPS = 4;
endpackage

// File: rtl/txcf_wr_ctrl.sv
module txcf_wr_ctrl #(
  parameter int unsigned PHYS_CELLS = 16,
  parameter int unsigned CELL_WORDS = 27,
  localparam int unsigned PTR_W = (PHYS_CELLS > 1) ? $clog2(PHYS_CELLS) : 1,
  localparam int unsigned WRD_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_drop_i,
  input  logic             space_i,
  output logic [PTR_W-1:0] slot_o,
  output logic [WRD_W-1:0] word_o,
  output logic             we_o,
  output logic             commit_o,
  output logic             in_cell_o
);
  logic [PTR_W-1:0] slot_q, slot_d;
  logic [WRD_W-1:0] word_q, word_d;
  logic             sink_q, sink_d;
  logic             start, last, accept, upd;

  always_comb begin
    start    = (word_q == '0);
    last     = (word_q == WRD_W'(CELL_WORDS - 1));
    // first word needs a free slot; later words follow the cell's fate
    accept   = wr_en_i && !wr_drop_i && (start ? space_i : !sink_q);
    commit_o = accept && last;
    upd      = wr_en_i || wr_drop_i;
    slot_d   = slot_q;
    word_d   = word_q;
    sink_d   = sink_q;
    if (wr_drop_i) begin
      word_d = '0;
      sink_d = 1'b0;
    end else if (wr_en_i) begin
      if (last) begin
        word_d = '0;
        sink_d = 1'b0;
      end else begin
        word_d = word_q + 1'b1;
        if (start) sink_d = !space_i;
      end
      if (commit_o)
        slot_d = (slot_q == PTR_W'(PHYS_CELLS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      word_q <= '0;
      sink_q <= 1'b0;
    end else if (upd) begin
      slot_q <= slot_d;
      word_q <= word_d;
      sink_q <= sink_d;
    end
  end

  assign slot_o    = slot_q;
  assign word_o    = word_q;
  assign we_o      = accept;
  assign in_cell_o = !start && !sink_q;
endmodule

// File: rtl/txcf_rd_ctrl.sv
module txcf_rd_ctrl #(
  parameter int unsigned PHYS_CELLS = 16,
  parameter int unsigned CELL_WORDS = 27,
  localparam int unsigned PTR_W = (PHYS_CELLS > 1) ? $clog2(PHYS_CELLS) : 1,
  localparam int unsigned WRD_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic             avail_i,
  output logic [PTR_W-1:0] slot_o,
  output logic [WRD_W-1:0] word_o,
  output logic             valid_o,
  output logic             soc_o,
  output logic             release_o
);
  logic [PTR_W-1:0] slot_q, slot_d;
  logic [WRD_W-1:0] word_q, word_d;
  logic             take, last;

  always_comb begin
    take      = rd_en_i && avail_i;
    last      = (word_q == WRD_W'(CELL_WORDS - 1));
    release_o = take && last;
    slot_d    = slot_q;
    word_d    = word_q;
    if (last) begin
      word_d = '0;
      slot_d = (slot_q == PTR_W'(PHYS_CELLS - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      word_d = word_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      word_q <= '0;
    end else if (take) begin
      slot_q <= slot_d;
      word_q <= word_d;
    end
  end

  assign slot_o  = slot_q;
  assign word_o  = word_q;
  assign valid_o = avail_i;
  assign soc_o   = avail_i && (word_q == '0);
endmodule

// File: rtl/txcf_occupancy.sv
module txcf_occupancy
  import txcf_pkg::*;
#(
  parameter int unsigned PHYS_CELLS = 16,
  localparam int unsigned CNT_W = $clog2(PHYS_CELLS + 1),
  localparam int unsigned QUART = PHYS_CELLS / DEPTH_STEPS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_i,
  input  logic       commit_i,
  input  logic       release_i,
  input  logic       in_cell_i,
  output logic       empty_o,
  output logic       full_o,
  output logic       space_o,
  output logic       avail_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] depth_q, depth_d, depth_dec, held;
  logic             idle, cnt_upd;

  always_comb begin
    depth_dec = CNT_W'((32'(cfg_i) + 32'd1) * QUART);
    idle      = (count_q == '0) && !in_cell_i;
    depth_d   = idle ? depth_dec : depth_q;
    cnt_upd   = commit_i ^ release_i;
    count_d   = count_q;
    if (commit_i && !release_i) count_d = count_q + 1'b1;
    if (release_i && !commit_i) count_d = count_q - 1'b1;
    held      = count_q + CNT_W'(in_cell_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (cnt_upd) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= CNT_W'(PHYS_CELLS);
    else if (idle) depth_q <= depth_d;
  end

  assign empty_o = (count_q == '0);
  assign avail_o = (count_q != '0);
  assign full_o  = (count_q == depth_q);
  assign space_o = (held < depth_q);
endmodule

// File: rtl/txcf_store.sv
module txcf_store #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned PHYS_CELLS = 16,
  parameter int unsigned CELL_WORDS = 27,
  localparam int unsigned PTR_W  = (PHYS_CELLS > 1) ? $clog2(PHYS_CELLS) : 1,
  localparam int unsigned WRD_W  = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1,
  localparam int unsigned DEPTH  = PHYS_CELLS * CELL_WORDS,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wslot_i,
  input  logic [WRD_W-1:0]  wword_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  rslot_i,
  input  logic [WRD_W-1:0]  rword_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] waddr, raddr;

  always_comb begin
    waddr = ADDR_W'(32'(wslot_i) * CELL_WORDS + 32'(wword_i));
    raddr = ADDR_W'(32'(rslot_i) * CELL_WORDS + 32'(rword_i));
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr] <= wdata_i;
  end

  assign rdata_o = mem[raddr];
endmodule

// File: rtl/txcell_fifo.sv
module txcell_fifo #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned PHYS_CELLS = 16,
  parameter int unsigned CELL_WORDS = 27,
  localparam int unsigned PTR_W = (PHYS_CELLS > 1) ? $clog2(PHYS_CELLS) : 1,
  localparam int unsigned WRD_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_depth,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_drop,
  output logic              cell_avail,
  output logic              fifo_empty,
  output logic              fifo_full,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_soc
);
  logic             rst_s1_q, rst_s2_q;
  logic [PTR_W-1:0] wslot, rslot;
  logic [WRD_W-1:0] wword, rword;
  logic             we, commit, in_cell, rel, space, avail;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  txcf_wr_ctrl #(.PHYS_CELLS(PHYS_CELLS), .CELL_WORDS(CELL_WORDS)) u_wr (
    .clk(clk), .rst_n(rst_s2_q), .wr_en_i(wr_en), .wr_drop_i(wr_drop),
    .space_i(space), .slot_o(wslot), .word_o(wword), .we_o(we),
    .commit_o(commit), .in_cell_o(in_cell)
  );

  txcf_rd_ctrl #(.PHYS_CELLS(PHYS_CELLS), .CELL_WORDS(CELL_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_s2_q), .rd_en_i(rd_en), .avail_i(avail),
    .slot_o(rslot), .word_o(rword), .valid_o(rd_valid), .soc_o(rd_soc),
    .release_o(rel)
  );

  txcf_occupancy #(.PHYS_CELLS(PHYS_CELLS)) u_occ (
    .clk(clk), .rst_n(rst_s2_q), .cfg_i(cfg_depth), .commit_i(commit),
    .release_i(rel), .in_cell_i(in_cell), .empty_o(fifo_empty),
    .full_o(fifo_full), .space_o(space), .avail_o(avail)
  );

  txcf_store #(.WORD_W(WORD_W), .PHYS_CELLS(PHYS_CELLS), .CELL_WORDS(CELL_WORDS)) u_mem (
    .clk(clk), .we_i(we), .wslot_i(wslot), .wword_i(wword), .wdata_i(wr_data),
    .rslot_i(rslot), .rword_i(rword), .rdata_o(rd_data)
  );

  assign cell_avail = space;
endmodule

// File: rtl/txcell_fifo_chk.sv
module txcell_fifo_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_drop,
  input logic              cell_avail,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_soc
);
  a_r6_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  a_r7_full_no_room: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !cell_avail);

  a_r4_soc_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_soc |-> rd_valid);

  a_r2_fill_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_empty) |-> $past(wr_en));

  a_r5_drop_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && fifo_empty) |=> fifo_empty);

  a_r10_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data) && $stable(rd_soc)));
endmodule

bind txcell_fifo txcell_fifo_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_drop(wr_drop),
  .cell_avail(cell_avail), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_soc(rd_soc)
);

// File: tb/sim_txcell_fifo.sv
module sim_txcell_fifo;
  localparam int CW = 27;

  logic        clk, rst_n;
  logic [1:0]  cfg_depth;
  logic        wr_en, wr_drop, rd_en;
  logic [15:0] wr_data;
  logic        cell_avail, fifo_empty, fifo_full;
  logic [15:0] rd_data;
  logic        rd_valid, rd_soc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  txcell_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .wr_en(wr_en),
    .wr_data(wr_data), .wr_drop(wr_drop), .cell_avail(cell_avail),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_soc(rd_soc)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_words(input int id, input int first, input int n);
    for (int w = first; w < first + n; w++) begin
      @(negedge clk);
      wr_en   = 1;
      wr_data = {id[7:0], w[7:0]};
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic write_cell(input int id);
    put_words(id, 0, CW);
  endtask

  task automatic read_cell(input int id, input string tag);
    for (int w = 0; w < CW; w++) begin
      @(negedge clk);
      chk(rd_valid, 1, {tag, " R2 valid"});
      chk(rd_data, {id[7:0], w[7:0]}, {tag, " R3 data"});
      chk(rd_soc, (w == 0), {tag, " R4 soc"});
      rd_en = 1;
    end
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic drop_pulse();
    @(negedge clk);
    wr_drop = 1;
    @(negedge clk);
    wr_drop = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(fifo_empty, 1, "R1 empty");
    chk(fifo_full, 0, "R1 full");
    chk(cell_avail, 1, "R1 avail");
    chk(rd_valid, 0, "R1 valid");
  endtask

  task automatic t_commit_visibility();
    put_words(1, 0, CW - 1);
    chk(rd_valid, 0, "R2 partial hidden");
    chk(fifo_empty, 1, "R2 partial empty");
    put_words(1, CW - 1, 1);
    chk(rd_valid, 1, "R2 visible after last");
    write_cell(2);
    read_cell(1, "seq1");
    read_cell(2, "seq2");
    @(negedge clk);
    chk(fifo_empty, 1, "R6 empty after drain");
  endtask

  task automatic t_drop();
    put_words(3, 0, 10);
    drop_pulse();
    chk(fifo_empty, 1, "R5 drop mid cell");
    // drop in the same cycle as a word
    put_words(4, 0, 5);
    @(negedge clk);
    wr_en = 1; wr_drop = 1; wr_data = 16'hDEAD;
    @(negedge clk);
    wr_en = 0; wr_drop = 0;
    write_cell(5);
    drop_pulse();  // no cell in progress: committed cell untouched
    chk(rd_valid, 1, "R5 idle drop keeps cell");
    read_cell(5, "R5 clean cell");
    @(negedge clk);
    chk(fifo_empty, 1, "R5 nothing extra");
  endtask

  task automatic t_depth4_full();
    cfg_depth = 2'd0;
    @(negedge clk);
    for (int c = 0; c < 3; c++) write_cell(16 + c);
    chk(cell_avail, 1, "R7 room at 3");
    put_words(19, 0, 1);
    chk(cell_avail, 0, "R7 in-progress takes slot");
    chk(fifo_full, 0, "R6 not full in progress");
    put_words(19, 1, CW - 1);
    chk(fifo_full, 1, "R6 full at 4");
    write_cell(99);  // offered while no room
    chk(fifo_full, 1, "R8 still full");
    for (int c = 0; c < 4; c++) read_cell(16 + c, "R8 order");
    @(negedge clk);
    chk(fifo_empty, 1, "R8 refused cell absent");
    write_cell(20);
    read_cell(20, "R8 next cell normal");
  endtask

  task automatic t_depth_change();
    write_cell(32);
    cfg_depth = 2'd3;
    for (int c = 1; c < 4; c++) write_cell(32 + c);
    chk(fifo_full, 1, "R9 old depth held");
    for (int c = 0; c < 4; c++) read_cell(32 + c, "R9 drain");
    @(negedge clk);
    for (int c = 0; c < 15; c++) write_cell(48 + c);
    chk(fifo_full, 0, "R6 depth16 at 15");
    chk(cell_avail, 1, "R7 depth16 room");
    write_cell(63);
    chk(fifo_full, 1, "R6 depth16 full");
    for (int c = 0; c < 16; c++) read_cell(48 + c, "R3 deep drain");
  endtask

  task automatic t_hold_and_overlap();
    @(negedge clk);
    rd_en = 1;  // empty: must do nothing
    @(negedge clk);
    rd_en = 0;
    write_cell(70);
    repeat (3) @(negedge clk);
    chk(rd_data, {8'd70, 8'd0}, "R10 hold data");
    chk(rd_soc, 1, "R10 hold soc");
    fork
      write_cell(71);
      read_cell(70, "R11 overlap read");
    join
    @(negedge clk);
    chk(fifo_empty, 0, "R11 one left");
    read_cell(71, "R11 second");
    @(negedge clk);
    chk(fifo_empty, 1, "R11 count back to zero");
  endtask

  initial begin
    rst_n = 0; cfg_depth = 2'd3;
    wr_en = 0; wr_drop = 0; wr_data = '0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_commit_visibility();
    t_drop();
    t_depth4_full();
    t_depth_change();
    t_hold_and_overlap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule